// File: doc/BRIEF.md
# SPI Shift Engine with Underrun and Collision Detection

This block is an 8-bit SPI shift engine that runs as either a bus master or a bus slave. Software loads one byte at a time into a single-entry transmit holding register. An empty flag tells software when that register can be written again. Every received byte is presented with a one-cycle valid strobe. As master, the engine makes SCK from the system clock using a programmable divider and drives the select output. As slave, it follows an external SCK and select after passing them through a two-flop synchronizer. In both roles it uses SPI mode 0: SCK idles low, data is sampled on the rising edge and shifted on the falling edge, most significant bit first.

The block detects two error conditions. Each one sets a sticky status bit that software clears by writing 1, and raises the interrupt. The first is a transmit underrun. How it is handled depends on the select-mode code. In framed master modes the transfer is aborted. In plain master modes SCK waits until software writes the next byte, and no error is raised. In slave mode the block sends all ones. The second is a collision between masters, seen on the select input while the block is master. On a collision the block stops driving the bus.

Top module: `spi_err_engine`

## Requirements
- R1: After reset: `tdre_o`=1, `status_o`=0, `irq_o`=0, `ss_out_no`=1, `sck_o`=0, `rx_valid_o`=0.
- R2: A write pulse on `wr_data_i` clears `tdre_o` on the next cycle. `tdre_o` returns to 1 in the cycle in which the held byte moves into the shift register.
- R3: In master mode SCK idles low and each SCK half period lasts `div_i`+1 clock cycles. MOSI carries the byte MSB first and is sampled by the far end on the rising edge. MISO is captured on the rising edge. At the end of each byte `rx_data_o` holds the captured byte and `rx_valid_o` pulses for one cycle. `ss_out_no` is low whenever `sck_o` is high.
- R4: In master mode with `ssmd_i` = 2'b00 or 2'b01, a byte that ends with `tdre_o`=1 does not set `status_o[0]`. SCK then stays low and `ss_out_no` stays low until the next write, after which shifting resumes with the new byte.
- R5: In master mode with `ssmd_i` = 2'b10 or 2'b11, a byte that ends with `tdre_o`=1 sets `status_o[0]` (underrun). It also stops SCK low and drives `ss_out_no` high.
- R6: In slave mode, a falling edge on the synchronized `ss_in_ni` with `tdre_o`=1 sets `status_o[0]`, and the byte shifted out on `miso_o` is 8'hFF. If `tdre_o`=0, the held byte is shifted out instead.
- R7: In slave mode, `mosi_i` is captured on each synchronized rising edge of `sck_i`. At the eighth falling edge `rx_data_o` holds the byte and `rx_valid_o` pulses. A following byte in the same select frame with no data held is padded with 8'hFF and is not flagged.
- R8: When `en_i`, `master_i`, `mm_en_i` and `ss_as_in_i` are all 1 and the synchronized `ss_in_ni` is low, `status_o[1]` (collision) is set. Any byte in progress is then aborted with SCK low and `ss_out_no` high. While `status_o[1]` is 1, `sck_oe_o` and `mosi_oe_o` are 0 and no new byte starts.
- R9: With `mm_en_i`=0, a low `ss_in_ni` in master mode never sets `status_o[1]`, and a byte completes normally.
- R10: Writing `st_wr_i` with a 1 in bit k of `st_wdata_i` clears `status_o[k]` (bit 0 underrun, bit 1 collision). A 0 in bit k leaves that status bit unchanged. A set event in the same cycle wins over a clear.
- R11: `irq_o` is 1 exactly when either status bit is 1.
- R12: Setting `en_i`=0 returns the engine to idle within one cycle, with `ss_out_no`=1 and `sck_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| master_i | input | 1 | 1 = master, 0 = slave |
| ssmd_i | input | 2 | Select mode: 00/01 plain, 10/11 framed |
| mm_en_i | input | 1 | Enable collision detection |
| ss_as_in_i | input | 1 | Select pin used as input |
| div_i | input | DIV_W | SCK half period minus one, in clock cycles |
| wr_data_i | input | 1 | Write strobe for the transmit holding register |
| wdata_i | input | DATA_W | Transmit byte |
| st_wr_i | input | 1 | Status write strobe |
| st_wdata_i | input | 2 | Status write data, 1 clears |
| tdre_o | output | 1 | Transmit holding register empty |
| status_o | output | 2 | {collision, underrun} |
| irq_o | output | 1 | Interrupt request |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| sck_i | input | 1 | SCK from the external master (slave mode) |
| mosi_i | input | 1 | MOSI from the external master (slave mode) |
| miso_i | input | 1 | MISO from the external slave (master mode) |
| ss_in_ni | input | 1 | Select input, active low |
| sck_o | output | 1 | Generated SCK |
| sck_oe_o | output | 1 | SCK drive enable |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe_o | output | 1 | MOSI drive enable |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe_o | output | 1 | MISO drive enable |
| ss_out_no | output | 1 | Select output, active low |
| ss_oe_o | output | 1 | Select drive enable |

## Verification
A data write is seen on `tdre_o` one cycle later. An idle master loads the byte and pulls `ss_out_no` low one cycle after that. The bench samples on the falling clock edge, so each of these checks lands in the cycle after the register that produces it. The underrun flag and the abort appear together with the `rx_valid_o` strobe of the last byte, and the bench checks them in the cycle where it observes that strobe. A select input change reaches the collision flag on the third rising edge, so the bench waits four cycles before it checks. Slave stimulus holds each SCK level for six cycles, which is more than the three-cycle synchronizer-and-edge delay, so every MISO sample is taken after the shift has settled.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;
  localparam int ST_W    = 2;
  localparam int UND_BIT = 0;
  localparam int COL_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } eng_state_t;

  typedef enum logic [1:0] {
    SEL_PLAIN0 = 2'b00,
    SEL_PLAIN1 = 2'b01,
    SEL_FRAME0 = 2'b10,
    SEL_FRAME1 = 2'b11
  } sel_mode_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_regs.sv
module spi_regs import spi_err_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic              st_wr_i,
  input  logic [ST_W-1:0]   st_wdata_i,
  input  logic              und_set_i,
  input  logic              col_set_i,
  output logic [DATA_W-1:0] tdr_o,
  output logic              tdre_o,
  output logic [ST_W-1:0]   status_o
);
  logic [DATA_W-1:0] tdr_q;
  logic              tdre_q;
  logic [ST_W-1:0]   set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr_q  <= '0;
      tdre_q <= 1'b1;
    end else if (wr_i) begin
      tdr_q  <= wdata_i;
      tdre_q <= 1'b0;
    end else if (load_i) begin
      tdre_q <= 1'b1;
    end
  end

  always_comb begin
    set_vec          = '0;
    set_vec[UND_BIT] = und_set_i;
    set_vec[COL_BIT] = col_set_i;
  end

  for (genvar gi = 0; gi < ST_W; gi++) begin : g_st
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= set_vec[gi] | (bit_q & ~(st_wr_i & st_wdata_i[gi]));
    end
    assign status_o[gi] = bit_q;
  end

  assign tdr_o  = tdr_q;
  assign tdre_o = tdre_q;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core import spi_err_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              framed_i,
  input  logic              fault_i,
  input  logic              col_i,
  input  logic [DATA_W-1:0] tdr_i,
  input  logic              tdre_i,
  input  logic              tick_i,
  input  logic              ss_s_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              miso_i,
  output logic              load_o,
  output logic              und_set_o,
  output logic              run_o,
  output logic              sck_o,
  output logic              ss_act_o,
  output logic              ser_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  eng_state_t        st_q;
  logic [DATA_W-1:0] sr_q, rx_q, rxd_q;
  logic [CNT_W-1:0]  bit_q;
  logic              sck_q, ss_act_q, rxv_q, ss_q, sck_s_q;
  logic              mst, slv, m_begin, m_last, s_start, s_rise, s_fall, s_last;

  assign mst     = en_i & master_i;
  assign slv     = en_i & ~master_i;
  assign m_begin = mst & ~fault_i & ~col_i & (st_q != ST_RUN) & ~tdre_i;
  assign m_last  = mst & ~fault_i & (st_q == ST_RUN) & tick_i & sck_q & (bit_q == LAST);
  assign s_start = slv & ~ss_s_i & ss_q;
  assign s_rise  = slv & ~ss_s_i & sck_s_i & ~sck_s_q;
  assign s_fall  = slv & ~ss_s_i & ~sck_s_i & sck_s_q;
  assign s_last  = s_fall & (bit_q == LAST);

  assign load_o    = m_begin | ((m_last | s_start | s_last) & ~tdre_i);
  assign und_set_o = (m_last & tdre_i & framed_i) | (s_start & tdre_i);
  assign run_o     = mst & ~fault_i & (st_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      sr_q     <= '0;
      rx_q     <= '0;
      rxd_q    <= '0;
      bit_q    <= '0;
      sck_q    <= 1'b0;
      ss_act_q <= 1'b0;
      rxv_q    <= 1'b0;
      ss_q     <= 1'b1;
      sck_s_q  <= 1'b0;
    end else begin
      rxv_q   <= 1'b0;
      ss_q    <= ss_s_i;
      sck_s_q <= sck_s_i;
      if (mst) begin
        if (fault_i) begin
          st_q     <= ST_IDLE;
          sck_q    <= 1'b0;
          ss_act_q <= 1'b0;
          bit_q    <= '0;
        end else if (m_begin) begin
          sr_q     <= tdr_i;
          st_q     <= ST_RUN;
          bit_q    <= '0;
          sck_q    <= 1'b0;
          ss_act_q <= 1'b1;
        end else if (st_q == ST_RUN && tick_i) begin
          sck_q <= ~sck_q;
          if (!sck_q) begin
            rx_q <= {rx_q[DATA_W-2:0], miso_i};
          end else if (bit_q == LAST) begin
            rxd_q <= rx_q;
            rxv_q <= 1'b1;
            bit_q <= '0;
            if (!tdre_i) sr_q <= tdr_i;
            else if (framed_i) begin
              st_q     <= ST_IDLE;
              ss_act_q <= 1'b0;
            end else st_q <= ST_PAUSE;
          end else begin
            sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        st_q     <= ST_IDLE;
        sck_q    <= 1'b0;
        ss_act_q <= 1'b0;
        if (!slv || ss_s_i) begin
          bit_q <= '0;
        end else if (s_start) begin
          sr_q  <= tdre_i ? '1 : tdr_i;
          bit_q <= '0;
        end else if (s_rise) begin
          rx_q <= {rx_q[DATA_W-2:0], mosi_s_i};
        end else if (s_last) begin
          rxd_q <= rx_q;
          rxv_q <= 1'b1;
          bit_q <= '0;
          sr_q  <= tdre_i ? '1 : tdr_i;  // continued byte without data is padded
        end else if (s_fall) begin
          sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign sck_o      = sck_q;
  assign ss_act_o   = ss_act_q;
  assign ser_o      = sr_q[DATA_W-1];
  assign rx_data_o  = rxd_q;
  assign rx_valid_o = rxv_q;
endmodule

// File: rtl/spi_err_engine.sv
module spi_err_engine import spi_err_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic [1:0]        ssmd_i,
  input  logic              mm_en_i,
  input  logic              ss_as_in_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              st_wr_i,
  input  logic [1:0]        st_wdata_i,
  output logic              tdre_o,
  output logic [1:0]        status_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              miso_i,
  input  logic              ss_in_ni,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              ss_out_no,
  output logic              ss_oe_o
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sync_q;
  logic              ss_s, sck_s, mosi_s;
  logic              framed, fault, tick, run, load, und_set, ss_act, ser;
  logic [DATA_W-1:0] tdr;

  spi_sync #(.W(SYNC_W), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_in_ni, sck_i, mosi_i}),
    .q_o    (sync_q)
  );
  assign {ss_s, sck_s, mosi_s} = sync_q;

  always_comb begin
    unique case (sel_mode_t'(ssmd_i))
      SEL_FRAME0, SEL_FRAME1: framed = 1'b1;
      default:                framed = 1'b0;
    endcase
  end

  assign fault = en_i & master_i & mm_en_i & ss_as_in_i & ~ss_s;

  spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .tick_o (tick)
  );

  spi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_data_i),
    .wdata_i    (wdata_i),
    .load_i     (load),
    .st_wr_i    (st_wr_i),
    .st_wdata_i (st_wdata_i),
    .und_set_i  (und_set),
    .col_set_i  (fault),
    .tdr_o      (tdr),
    .tdre_o     (tdre_o),
    .status_o   (status_o)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .master_i   (master_i),
    .framed_i   (framed),
    .fault_i    (fault),
    .col_i      (status_o[COL_BIT]),
    .tdr_i      (tdr),
    .tdre_i     (tdre_o),
    .tick_i     (tick),
    .ss_s_i     (ss_s),
    .sck_s_i    (sck_s),
    .mosi_s_i   (mosi_s),
    .miso_i     (miso_i),
    .load_o     (load),
    .und_set_o  (und_set),
    .run_o      (run),
    .sck_o      (sck_o),
    .ss_act_o   (ss_act),
    .ser_o      (ser),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  assign irq_o     = |status_o;
  assign mosi_o    = ser;
  assign miso_o    = ser;
  assign ss_out_no = ~ss_act;
  assign sck_oe_o  = en_i & master_i & ~status_o[COL_BIT];
  assign mosi_oe_o = en_i & master_i & ~status_o[COL_BIT];
  assign miso_oe_o = en_i & ~master_i & ~ss_s;
  assign ss_oe_o   = en_i & master_i & ~ss_as_in_i;
endmodule

// File: rtl/spi_err_chk.sv
module spi_err_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       master_i,
  input logic [1:0] ssmd_i,
  input logic       mm_en_i,
  input logic       ss_as_in_i,
  input logic       wr_data_i,
  input logic       st_wr_i,
  input logic [1:0] st_wdata_i,
  input logic       tdre_o,
  input logic [1:0] status_o,
  input logic       rx_valid_o,
  input logic       sck_o,
  input logic       ss_out_no
);
  assert_tdre_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> !tdre_o);

  assert_sck_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i && sck_o) |-> !ss_out_no);

  assert_rxv_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_plain_no_und_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> !($past(en_i) && $past(master_i) &&
                             ($past(ssmd_i) inside {2'b00, 2'b01})));

  assert_und_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o[0]) && en_i && master_i) |-> (ss_out_no && !sck_o));

  assert_col_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> (ss_out_no && !sck_o));

  assert_col_needs_mm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> ($past(mm_en_i) && $past(ss_as_in_i) && $past(master_i)));

  assert_und_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !(st_wr_i && st_wdata_i[0])) |=> status_o[0]);

  assert_col_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !(st_wr_i && st_wdata_i[1])) |=> status_o[1]);

  assert_disable_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ss_out_no && !sck_o));
endmodule

bind spi_err_engine spi_err_chk u_chk (.*);

// File: tb/spi_err_engine_tb.sv
module spi_err_engine_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, master_i = 1'b1, mm_en_i = 1'b0, ss_as_in_i = 1'b0;
  logic [1:0] ssmd_i = 2'b00;
  logic [7:0] div_i = 8'd1;
  logic       wr_data_i = 1'b0, st_wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [1:0] st_wdata_i = '0;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_in_ni = 1'b1, miso_i;
  logic       tdre_o, irq_o, rx_valid_o;
  logic [1:0] status_o;
  logic [7:0] rx_data_o;
  logic       sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o, ss_out_no, ss_oe_o;

  int n_chk = 0, n_bad = 0;

  // bench-side serial model state
  logic       mon_on = 1'b0;
  logic [7:0] miso_byte = '0;
  logic [7:0] mb = '0;
  logic       sck_prev = 1'b0;
  int         mn = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  spi_err_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .master_i(master_i), .ssmd_i(ssmd_i),
    .mm_en_i(mm_en_i), .ss_as_in_i(ss_as_in_i), .div_i(div_i), .wr_data_i(wr_data_i),
    .wdata_i(wdata_i), .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i), .tdre_o(tdre_o),
    .status_o(status_o), .irq_o(irq_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i), .ss_in_ni(ss_in_ni),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .ss_out_no(ss_out_no), .ss_oe_o(ss_oe_o)
  );

  assign miso_i = miso_byte[3'(7 - mn)];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock model: reassemble MOSI bytes, check framing and interrupt
  always @(negedge clk) begin
    if (!mon_on) mn = 0;
    else if (sck_o && !sck_prev) begin
      mb = {mb[6:0], mosi_o};
      mn++;
      if (mn == 8) begin
        mn = 0;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected mosi byte", int'(mb), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(mb == e, "R3 mosi byte", int'(mb), int'(e));
        end
      end
    end
    if (rst_ni && en_i && master_i && sck_o)
      chk(!ss_out_no, "R3 select low while sck high", int'(ss_out_no), 0);
    if (rst_ni) chk(irq_o == |status_o, "R11 irq follows status", int'(irq_o), int'(|status_o));
    sck_prev = sck_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tx(input logic [7:0] b);
    wdata_i = b; wr_data_i = 1'b1;
    @(negedge clk);
    wr_data_i = 1'b0;
  endtask

  task automatic wr_st(input logic [1:0] v);
    st_wdata_i = v; st_wr_i = 1'b1;
    @(negedge clk);
    st_wr_i = 1'b0;
  endtask

  task automatic wait_rxv(input string tag);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rx_valid_o) return;
    end
    chk(1'b0, tag, 0, 1);
  endtask

  task automatic sl_xfer(input logic [7:0] mo, output logic [7:0] mi);
    ss_in_ni = 1'b0;
    tick(6);
    for (int i = 0; i < 8; i++) begin
      mosi_i = mo[7 - i];
      tick(6);
      mi[7 - i] = miso_o;
      sck_i = 1'b1;
      tick(6);
      sck_i = 1'b0;
    end
    tick(6);
    ss_in_ni = 1'b1;
    tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    chk(tdre_o == 1'b1, "R1 tdre", int'(tdre_o), 1);
    chk(status_o == 2'b00, "R1 status", int'(status_o), 0);
    chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    chk(ss_out_no == 1'b1 && sck_o == 1'b0, "R1 select/sck idle", int'({ss_out_no, sck_o}), 2);
    chk(rx_valid_o == 1'b0, "R1 rx_valid", int'(rx_valid_o), 0);

    // plain master: pause and resume
    en_i = 1'b1; master_i = 1'b1; ssmd_i = 2'b00; div_i = 8'd1;
    mon_on = 1'b1; miso_byte = 8'h3C; exp_q.push_back(8'hA5);
    wr_tx(8'hA5);
    chk(tdre_o == 1'b0, "R2 tdre cleared by write", int'(tdre_o), 0);
    tick(1);
    chk(tdre_o == 1'b1, "R2 tdre set on load", int'(tdre_o), 1);
    chk(ss_out_no == 1'b0, "R3 select asserted at start", int'(ss_out_no), 0);
    wait_rxv("R3 rx_valid timeout");
    chk(rx_data_o == 8'h3C, "R3 master rx byte", int'(rx_data_o), 'h3C);
    tick(40);
    chk(sck_o == 1'b0, "R4 sck paused low", int'(sck_o), 0);
    chk(ss_out_no == 1'b0, "R4 select held in pause", int'(ss_out_no), 0);
    chk(status_o == 2'b00, "R4 no underrun in plain mode", int'(status_o), 0);
    chk(exp_q.size() == 0, "R3 first byte shifted", exp_q.size(), 0);
    miso_byte = 8'hC3; exp_q.push_back(8'h5A);
    wr_tx(8'h5A);
    wait_rxv("R4 resume timeout");
    chk(rx_data_o == 8'hC3, "R4 resumed rx byte", int'(rx_data_o), 'hC3);
    chk(exp_q.size() == 0, "R4 resumed byte shifted", exp_q.size(), 0);
    en_i = 1'b0;
    tick(2);
    chk(ss_out_no == 1'b1 && sck_o == 1'b0, "R12 disable returns idle", int'({ss_out_no, sck_o}), 2);

    // framed master: underrun abort
    en_i = 1'b1; ssmd_i = 2'b10; miso_byte = 8'h00;
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    wr_tx(8'h11);
    for (int i = 0; i < 20 && !tdre_o; i++) tick(1);
    wr_tx(8'h22);
    wait_rxv("R5 first byte timeout");
    chk(status_o[0] == 1'b0, "R5 no underrun while data ready", int'(status_o[0]), 0);
    wait_rxv("R5 second byte timeout");
    chk(status_o[0] == 1'b1, "R5 underrun flagged", int'(status_o[0]), 1);
    chk(ss_out_no == 1'b1, "R5 select deasserted", int'(ss_out_no), 1);
    tick(20);
    chk(sck_o == 1'b0, "R5 sck stopped", int'(sck_o), 0);
    chk(irq_o == 1'b1, "R11 irq on underrun", int'(irq_o), 1);
    chk(exp_q.size() == 0, "R5 both bytes shifted", exp_q.size(), 0);

    // write-1-to-clear
    wr_st(2'b10);
    chk(status_o == 2'b01, "R10 other bit write leaves underrun", int'(status_o), 1);
    wr_st(2'b00);
    chk(status_o == 2'b01, "R10 zero write no effect", int'(status_o), 1);
    wr_st(2'b01);
    chk(status_o == 2'b00, "R10 underrun cleared", int'(status_o), 0);
    chk(irq_o == 1'b0, "R11 irq drops", int'(irq_o), 0);

    // slave: underrun pad then loaded data
    mon_on = 1'b0; master_i = 1'b0; ssmd_i = 2'b00;
    tick(2);
    sl_xfer(8'hC3, got);
    chk(got == 8'hFF, "R6 slave pads all ones", int'(got), 'hFF);
    chk(status_o[0] == 1'b1, "R6 slave underrun flagged", int'(status_o[0]), 1);
    chk(rx_data_o == 8'hC3, "R7 slave rx byte", int'(rx_data_o), 'hC3);
    wr_st(2'b01);
    wr_tx(8'h96);
    chk(tdre_o == 1'b0, "R2 tdre cleared in slave", int'(tdre_o), 0);
    sl_xfer(8'h69, got);
    chk(got == 8'h96, "R6 slave sends loaded byte", int'(got), 'h96);
    chk(status_o == 2'b00, "R7 no flag on continued pad", int'(status_o), 0);
    chk(rx_data_o == 8'h69, "R7 slave rx second byte", int'(rx_data_o), 'h69);
    chk(tdre_o == 1'b1, "R2 tdre set after slave load", int'(tdre_o), 1);

    // collision
    master_i = 1'b1; mm_en_i = 1'b1; ss_as_in_i = 1'b1; div_i = 8'd3;
    tick(2);
    chk(ss_oe_o == 1'b0, "R8 select not driven when input", int'(ss_oe_o), 0);
    wr_tx(8'h77);
    tick(10);
    ss_in_ni = 1'b0;
    tick(4);
    chk(status_o[1] == 1'b1, "R8 collision flagged", int'(status_o[1]), 1);
    chk(sck_oe_o == 1'b0 && mosi_oe_o == 1'b0, "R8 drivers released",
        int'({sck_oe_o, mosi_oe_o}), 0);
    chk(sck_o == 1'b0 && ss_out_no == 1'b1, "R8 transfer aborted", int'({sck_o, ss_out_no}), 1);
    ss_in_ni = 1'b1;
    wr_tx(8'h55);
    tick(20);
    chk(sck_o == 1'b0 && tdre_o == 1'b0, "R8 no restart while flagged",
        int'({sck_o, tdre_o}), 0);
    wr_st(2'b01);
    chk(status_o[1] == 1'b1, "R10 collision kept on other bit", int'(status_o[1]), 1);
    wr_tx(8'h00);
    wr_st(2'b10);
    chk(status_o == 2'b00, "R10 collision cleared", int'(status_o), 0);
    chk(sck_oe_o == 1'b1, "R8 drivers back", int'(sck_oe_o), 1);
    tick(80);

    // no collision without enable
    mm_en_i = 1'b0; ss_in_ni = 1'b0;
    tick(1);
    mon_on = 1'b1; miso_byte = 8'h81; exp_q.push_back(8'hEE);
    wr_tx(8'hEE);
    wait_rxv("R9 byte timeout");
    chk(status_o == 2'b00, "R9 no collision when disabled", int'(status_o), 0);
    chk(rx_data_o == 8'h81, "R9 byte completes", int'(rx_data_o), 'h81);
    chk(exp_q.size() == 0, "R9 byte shifted", exp_q.size(), 0);
    ss_in_ni = 1'b1;
    tick(4);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule